// File: doc/BRIEF.md
# Relocatable Interrupt Vector Controller

This block sits beside a small processor core. It picks the most urgent pending interrupt and gives the word address of that interrupt's vector. The vector table can sit in one of two places: the bottom of the application area, or the start of the boot area. The reset address can also come from either area, set by a configuration bit. An 8-bit control register holds the table-placement bit and two external-line enables.

The table-placement bit is protected. It changes only when a change-enable write comes first and the placement write follows within a short window. From the change-enable write onward, interrupt taking is held off. That hold-off touches only the take decision and never the core's global enable.

Two protection bits can also suppress interrupts. Each one acts when the code running sits in the area that does not hold the table.

Top module: `ivec_ctrl`

## Requirements
- R1: A synchronous active-high reset clears the control register, `take` and `vec_addr`. After reset the table sits in the application area and request bits 0 and 1 are masked.
- R2: Request bit k is served by vector number k+1, for k from 0 to 17. Among requests that are pending and enabled, the lowest-numbered vector wins.
- R3: When the placement bit is 0, vector n is at word address n. When it is 1, vector n is at `boot_start` + n.
- R4: `rst_addr` is 0 when `boot_rst_cfg` is 1 and equals `boot_start` when it is 0, whatever the placement bit holds. It follows the inputs one clock later.
- R5: A write with data bit 0 = 0 while no window is open leaves the placement bit unchanged.
- R6: A write with data bit 0 = 1 opens a window, and leaves the placement bit unchanged even if bit 1 is set. In each of the 3 cycles after that write, a write with bit 0 = 0 loads data bit 1 into the placement bit and closes the window. If no such write arrives, the window closes by itself after those 3 cycles.
- R7: No interrupt is taken in the cycle of a window-opening write, nor during the open window. A window that expires therefore blocks for 4 cycles in total.
- R8: After a placement write, taking stays blocked up to and including the next cycle with `instr_done` = 1. Taking resumes in the cycle after that.
- R9: An interrupt is taken in a cycle only if `gie` = 1, `instr_done` = 1, no block is active and an enabled request is pending. `take` then pulses high in the next cycle, with `vec_addr` set to that vector's address.
- R10: With the table in the boot area, `lock_app` = 1 blocks taking while `pc_in_boot` = 0. With the table in the application area, `lock_boot` = 1 blocks taking while `pc_in_boot` = 1.
- R11: Register bit 6 gates request bit 0 and register bit 7 gates request bit 1. Any write loads these two bits, with or without a window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Control register write strobe |
| reg_wr_data | input | 8 | Write data: bit 7 line-2 enable, bit 6 line-1 enable, bit 1 placement, bit 0 change-enable |
| instr_done | input | 1 | High in the cycle an instruction completes |
| irq_req | input | 18 | Interrupt request lines; bit k maps to vector k+1 |
| irq_en | input | 18 | Per-line enables |
| gie | input | 1 | Global interrupt enable |
| boot_rst_cfg | input | 1 | 1: reset at address 0; 0: reset at boot start |
| boot_start | input | 12 | Boot area start word address |
| lock_app | input | 1 | Protection active for code in the application area |
| lock_boot | input | 1 | Protection active for code in the boot area |
| pc_in_boot | input | 1 | Program counter lies in the boot area |
| rst_addr | output | 12 | Reset word address |
| take | output | 1 | Interrupt-take pulse |
| vec_addr | output | 12 | Vector word address of the taken interrupt |

## Verification
The sharpest collision puts an interrupt that qualifies on every other count into the same cycle as a window-opening register write. The bench raises a request together with that write, then samples `take` for the write cycle and each window cycle until the first permitted pulse. A second collision puts a placement write on an instruction boundary. The bench holds `instr_done` high during the write and judges that exactly one further boundary is skipped. The first pulse after that must already carry the relocated address.

// File: rtl/ivec_pkg.sv
package ivec_pkg;
  localparam int CTRL_W    = 8;
  localparam int BIT_LINE2 = 7;
  localparam int BIT_LINE1 = 6;
  localparam int BIT_PLACE = 1;
  localparam int BIT_UNLK  = 0;

  typedef struct packed {
    logic line2_en;
    logic line1_en;
    logic place;
    logic unlk;
  } ctrl_t;
endpackage

// File: rtl/ivec_regs.sv
module ivec_regs
  import ivec_pkg::*;
#(
  parameter int WIN_CYC = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  input  logic              instr_done,
  output ctrl_t             ctrl,
  output logic              open_now,
  output logic              post_hold
);
  localparam int CNT_W = $clog2(WIN_CYC + 1);

  logic [CNT_W-1:0] win_left;
  logic             place_wr;
  logic             unused_rsvd;

  assign unused_rsvd = ^wr_data[5:2];
  assign open_now    = wr_en & wr_data[BIT_UNLK];
  assign place_wr    = wr_en & ctrl.unlk & ~wr_data[BIT_UNLK];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl      <= '0;
      win_left  <= '0;
      post_hold <= 1'b0;
    end else begin
      if (wr_en) begin
        ctrl.line1_en <= wr_data[BIT_LINE1];
        ctrl.line2_en <= wr_data[BIT_LINE2];
      end
      if (open_now) begin
        ctrl.unlk <= 1'b1;
        win_left  <= CNT_W'(WIN_CYC - 1);
      end else if (place_wr) begin
        ctrl.place <= wr_data[BIT_PLACE];
        ctrl.unlk  <= 1'b0;
        win_left   <= '0;
      end else if (ctrl.unlk) begin
        if (win_left <= CNT_W'(1)) begin
          ctrl.unlk <= 1'b0;
          win_left  <= '0;
        end else begin
          win_left <= win_left - CNT_W'(1);
        end
      end
      if (place_wr)
        post_hold <= 1'b1;
      else if (instr_done)
        post_hold <= 1'b0;
    end
  end
endmodule

// File: rtl/ivec_prio.sv
module ivec_prio #(
  parameter int NUM_SRC = 18,
  parameter int IDX_W   = $clog2(NUM_SRC + 1)
) (
  input  logic [NUM_SRC-1:0] req,
  output logic               any,
  output logic [IDX_W-1:0]   idx
);
  always_comb begin
    idx = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i + 1);
    end
  end
  assign any = |req;
endmodule

// File: rtl/ivec_guard.sv
module ivec_guard (
  input  logic open_now,
  input  logic unlk,
  input  logic post_hold,
  input  logic place,
  input  logic lock_app,
  input  logic lock_boot,
  input  logic pc_in_boot,
  output logic hold
);
  logic lock_hit;

  assign lock_hit = (place & lock_app & ~pc_in_boot) |
                    (~place & lock_boot & pc_in_boot);
  assign hold     = open_now | unlk | post_hold | lock_hit;
endmodule

// File: rtl/ivec_ctrl.sv
module ivec_ctrl
  import ivec_pkg::*;
#(
  parameter int NUM_SRC = 18,
  parameter int ADDR_W  = 12,
  parameter int WIN_CYC = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_wr_en,
  input  logic [CTRL_W-1:0]  reg_wr_data,
  input  logic               instr_done,
  input  logic [NUM_SRC-1:0] irq_req,
  input  logic [NUM_SRC-1:0] irq_en,
  input  logic               gie,
  input  logic               boot_rst_cfg,
  input  logic [ADDR_W-1:0]  boot_start,
  input  logic               lock_app,
  input  logic               lock_boot,
  input  logic               pc_in_boot,
  output logic [ADDR_W-1:0]  rst_addr,
  output logic               take,
  output logic [ADDR_W-1:0]  vec_addr
);
  localparam int IDX_W = $clog2(NUM_SRC + 1);

  ctrl_t              ctrl;
  logic               open_now;
  logic               post_hold;
  logic               hold;
  logic               chg_en;
  logic               vec_sel;
  logic [NUM_SRC-1:0] live_req;
  logic               any_req;
  logic [IDX_W-1:0]   win_idx;
  logic               fire;
  logic [ADDR_W-1:0]  tbl_base;
  logic [ADDR_W-1:0]  vec_next;
  logic [ADDR_W-1:0]  rst_next;

  ivec_regs #(.WIN_CYC(WIN_CYC)) u_regs (
    .clk(clk), .rst(rst), .wr_en(reg_wr_en), .wr_data(reg_wr_data),
    .instr_done(instr_done), .ctrl(ctrl), .open_now(open_now),
    .post_hold(post_hold)
  );

  assign chg_en  = ctrl.unlk;
  assign vec_sel = ctrl.place;

  always_comb begin
    live_req    = irq_req & irq_en;
    live_req[0] = live_req[0] & ctrl.line1_en;
    live_req[1] = live_req[1] & ctrl.line2_en;
  end

  ivec_prio #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_prio (
    .req(live_req), .any(any_req), .idx(win_idx)
  );

  ivec_guard u_guard (
    .open_now(open_now), .unlk(chg_en), .post_hold(post_hold),
    .place(vec_sel), .lock_app(lock_app), .lock_boot(lock_boot),
    .pc_in_boot(pc_in_boot), .hold(hold)
  );

  assign fire     = gie & instr_done & ~hold & any_req;
  assign tbl_base = vec_sel ? boot_start : '0;
  assign vec_next = tbl_base + ADDR_W'(win_idx);
  assign rst_next = boot_rst_cfg ? '0 : boot_start;

  always_ff @(posedge clk) begin
    if (rst) begin
      take     <= 1'b0;
      vec_addr <= '0;
      rst_addr <= rst_next;
    end else begin
      take     <= fire;
      rst_addr <= rst_next;
      if (fire) vec_addr <= vec_next;
    end
  end
endmodule

// File: rtl/ivec_ctrl_chk.sv
module ivec_ctrl_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_wr_en,
  input logic [7:0]        reg_wr_data,
  input logic              instr_done,
  input logic              gie,
  input logic              boot_rst_cfg,
  input logic              lock_app,
  input logic              lock_boot,
  input logic              pc_in_boot,
  input logic [ADDR_W-1:0] rst_addr,
  input logic              take,
  input logic              chg_en,
  input logic              vec_sel,
  input logic              post_hold
);
  p_place_guard_r5: assert property (@(posedge clk) disable iff (rst)
    !(chg_en && reg_wr_en && !reg_wr_data[0]) |=> $stable(vec_sel));

  p_unlock_clears_r6: assert property (@(posedge clk) disable iff (rst)
    (chg_en && reg_wr_en && !reg_wr_data[0]) |=> !chg_en);

  p_open_blocks_r7: assert property (@(posedge clk) disable iff (rst)
    (reg_wr_en && reg_wr_data[0]) |=> !take);

  p_window_blocks_r7: assert property (@(posedge clk) disable iff (rst)
    chg_en |=> !take);

  p_post_blocks_r8: assert property (@(posedge clk) disable iff (rst)
    post_hold |=> !take);

  p_take_qualified_r9: assert property (@(posedge clk) disable iff (rst)
    take |-> ($past(gie) && $past(instr_done)));

  p_lock_respected_r10: assert property (@(posedge clk) disable iff (rst)
    take |-> !($past(vec_sel) ? ($past(lock_app) && !$past(pc_in_boot))
                              : ($past(lock_boot) && $past(pc_in_boot))));

  p_reset_low_r4: assert property (@(posedge clk) disable iff (rst)
    boot_rst_cfg |=> (rst_addr == '0));
endmodule

bind ivec_ctrl ivec_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
  .instr_done(instr_done), .gie(gie), .boot_rst_cfg(boot_rst_cfg),
  .lock_app(lock_app), .lock_boot(lock_boot), .pc_in_boot(pc_in_boot),
  .rst_addr(rst_addr), .take(take), .chg_en(chg_en), .vec_sel(vec_sel),
  .post_hold(post_hold)
);

// File: tb/ivec_ctrl_tb.sv
`timescale 1ns/1ps
module ivec_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        reg_wr_en;
  logic [7:0]  reg_wr_data;
  logic        instr_done;
  logic [17:0] irq_req;
  logic [17:0] irq_en;
  logic        gie;
  logic        boot_rst_cfg;
  logic [11:0] boot_start;
  logic        lock_app;
  logic        lock_boot;
  logic        pc_in_boot;
  logic [11:0] rst_addr;
  logic        take;
  logic [11:0] vec_addr;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  ivec_ctrl u_dut (
    .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
    .instr_done(instr_done), .irq_req(irq_req), .irq_en(irq_en), .gie(gie),
    .boot_rst_cfg(boot_rst_cfg), .boot_start(boot_start),
    .lock_app(lock_app), .lock_boot(lock_boot), .pc_in_boot(pc_in_boot),
    .rst_addr(rst_addr), .take(take), .vec_addr(vec_addr)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr_reg(input logic [7:0] d);
    reg_wr_en   = 1'b1;
    reg_wr_data = d;
    @(negedge clk);
    reg_wr_en   = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 take in reset", take, 0);
    chk("R1 vec_addr in reset", vec_addr, 0);
    chk("R4 rst_addr cfg=1", rst_addr, 0);
    rst = 1'b0;
    irq_req = 18'h1;
    step();
    chk("R11 line 1 masked after reset", take, 0);
    irq_req = '0;
    step();
  endtask

  task automatic t_priority();
    irq_req = (18'h1 << 5) | (18'h1 << 9);
    step();
    chk("R2 take", take, 1);
    chk("R2 lowest wins", vec_addr, 12'h006);
    irq_req = 18'h1 << 17;
    step();
    chk("R2 top source", vec_addr, 12'h012);
    irq_req = '1;
    irq_en  = (18'h1 << 3) | (18'h1 << 17);
    step();
    chk("R2 enable mask", vec_addr, 12'h004);
    irq_en  = '1;
    irq_req = '0;
    step();
    chk("R9 nothing pending", take, 0);
  endtask

  task automatic t_qualify();
    irq_req = 18'h1 << 4;
    gie = 1'b0;
    step();
    chk("R9 gie low", take, 0);
    gie = 1'b1;
    instr_done = 1'b0;
    step();
    chk("R9 no boundary", take, 0);
    instr_done = 1'b1;
    step();
    chk("R9 take", take, 1);
    chk("R9 vec", vec_addr, 12'h005);
    irq_req = '0;
    step();
  endtask

  task automatic t_line_en();
    wr_reg(8'hC0);
    irq_req = 18'h1;
    step();
    chk("R11 line 1 enabled", vec_addr, 12'h001);
    irq_req = 18'h2;
    step();
    chk("R11 line 2 enabled", vec_addr, 12'h002);
    irq_req = '0;
    step();
  endtask

  task automatic t_ignore();
    wr_reg(8'hC2);
    irq_req = 18'h1 << 3;
    step();
    chk("R5 placement write ignored", vec_addr, 12'h004);
    irq_req = '0;
    step();
  endtask

  task automatic t_expire();
    irq_req = 18'h1 << 3;
    wr_reg(8'hC1);
    chk("R7 open cycle blocks", take, 0);
    for (int i = 0; i < 3; i++) begin
      step();
      chk("R7 window blocks", take, 0);
    end
    step();
    chk("R7 take after expiry", take, 1);
    wr_reg(8'hC2);
    chk("R5 late write ignored take", take, 1);
    chk("R5 late write ignored vec", vec_addr, 12'h004);
    irq_req = '0;
    step();
  endtask

  task automatic t_switch();
    irq_req = 18'h1 << 3;
    wr_reg(8'hC1);
    wr_reg(8'hC2);
    chk("R7 window cycle blocks", take, 0);
    step();
    chk("R8 next boundary blocked", take, 0);
    step();
    chk("R8 take resumes", take, 1);
    chk("R3 boot-area vector", vec_addr, 12'hC04);
    wr_reg(8'hC0);
    chk("R6 window closed by placement write", vec_addr, 12'hC04);
    lock_app = 1'b1;
    step();
    step();
    chk("R10 app lock, boot table", take, 0);
    pc_in_boot = 1'b1;
    step();
    chk("R10 boot code allowed", take, 1);
    lock_app = 1'b0;
    pc_in_boot = 1'b0;
    irq_req = '0;
    wr_reg(8'hC1);
    wr_reg(8'hC0);
    repeat (3) step();
    irq_req = 18'h1 << 3;
    step();
    chk("R3 back to application area", vec_addr, 12'h004);
    irq_req = '0;
    step();
  endtask

  task automatic t_lock_app_tbl();
    irq_req = 18'h1 << 3;
    lock_boot = 1'b1;
    pc_in_boot = 1'b1;
    step();
    step();
    chk("R10 boot lock, app table", take, 0);
    pc_in_boot = 1'b0;
    step();
    chk("R10 app code allowed", take, 1);
    lock_boot = 1'b0;
    lock_app  = 1'b1;
    step();
    chk("R10 app lock ignored for app table", take, 1);
    lock_app = 1'b0;
    irq_req = '0;
    step();
  endtask

  task automatic t_both_bits();
    irq_req = 18'h1 << 3;
    wr_reg(8'hC3);
    chk("R6 open write blocks", take, 0);
    for (int i = 0; i < 3; i++) begin
      step();
      chk("R6 window open", take, 0);
    end
    step();
    chk("R6 take", take, 1);
    chk("R6 opening write keeps placement", vec_addr, 12'h004);
    irq_req = '0;
    step();
  endtask

  task automatic t_rst_addr();
    boot_rst_cfg = 1'b0;
    step();
    chk("R4 boot reset", rst_addr, 12'hC00);
    boot_start = 12'h800;
    step();
    chk("R4 follows boot start", rst_addr, 12'h800);
    boot_rst_cfg = 1'b1;
    step();
    chk("R4 back to zero", rst_addr, 12'h000);
  endtask

  initial begin
    rst = 1'b1;
    reg_wr_en = 1'b0;
    reg_wr_data = '0;
    instr_done = 1'b1;
    irq_req = '0;
    irq_en = '1;
    gie = 1'b1;
    boot_rst_cfg = 1'b1;
    boot_start = 12'hC00;
    lock_app = 1'b0;
    lock_boot = 1'b0;
    pc_in_boot = 1'b0;
    repeat (4) step();
    t_reset();
    t_priority();
    t_qualify();
    t_line_en();
    t_ignore();
    t_expire();
    t_switch();
    t_lock_app_tbl();
    t_both_bits();
    t_rst_addr();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule